// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block performs two's-complement addition, subtraction, increment, decrement and negation on 8-, 16- or 32-bit operands. For each operation it returns the result and six new status flag values: carry, overflow, sign, zero, auxiliary (nibble) carry and parity. It also returns a write enable for each flag.

The flags register lives outside the block. The block only proposes new flag values and says which of them should be written. The current carry flag enters on `carry_in`. Increment and decrement pass it back unchanged, with the carry write enable held low.

Operations enter on a valid/ready stream and leave on a second valid/ready stream, one register stage later. The input side is ready whenever the output stage is empty or is being drained in the same cycle. While the output is stalled the result is held.

Top module: `addsub_flag_unit`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An operation accepted at a clock edge (`in_valid` and `in_ready` high) appears on the outputs with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `result`, `flags` and `flag_we` hold their values.
- R2: `op` encodes 0 add (a+b), 1 subtract (a−b), 2 increment (a+1), 3 decrement (a−1) and 4 negate (0−a); codes 5 to 7 act as add. `width_sel` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the width are ignored, and result bits above the width are zero.
- R3: The carry flag (`flags[0]`) is the carry out of the top bit of the width for add. For subtract, decrement and negate it is the inverse of that carry, i.e. the unsigned borrow.
- R4: The overflow flag (`flags[5]`) is the carry into the top bit XOR the carry out of it. It is set only when the result's sign is wrong for the signed operation; for example, 80h+80h at byte width gives carry 1 and overflow 1.
- R5: The auxiliary flag (`flags[2]`) is the carry out of bit 3 for add and increment, and its inverse (the nibble borrow) for subtract, decrement and negate.
- R6: The sign flag (`flags[4]`) copies the top result bit of the active width. The zero flag (`flags[3]`) is set when the result at that width is all zeros. For example, 7FFFh+1 at word width sets overflow and sign.
- R7: The parity flag (`flags[1]`) is 1 when `result[7:0]` holds an even number of ones, at every width.
- R8: For increment and decrement, `flag_we[0]` is 0 and `flags[0]` equals the `carry_in` sampled with the operation. All other write enables are 1.
- R9: Negate gives carry 1 unless the operand (at width) is zero. It gives overflow 1 only for the most negative value of the width. Its auxiliary flag is 0 when the operand's low nibble is zero.
- R10: For add, subtract and negate, all six bits of `flag_we` are 1.
- R11: During and right after reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| op | input | 3 | Operation code (R2) |
| width_sel | input | 2 | Operand width select (R2) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (add/subtract only) |
| carry_in | input | 1 | Present carry flag, passed through by increment/decrement |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| result | output | 32 | Result, zero above the active width |
| flags | output | 6 | {overflow, sign, zero, aux, parity, carry} |
| flag_we | output | 6 | Per-flag write enables, same bit order as `flags` |

## Verification
The bench uses directed corner operands and then several hundred pseudorandom operations across all widths and codes.

- The directed cases are: 80h+80h, 7FFFh+1, equal-operand subtraction, negation of zero, of the most negative value and of a value with a clear low nibble, and increment and decrement with both carry_in values.
- Between them, these cases separate the carry out of the top bit from the carry into it. They also separate a borrow from a carry, and parity of the low byte from parity of the whole word.
- Results above the width, and operand bits above it, separate correct masking from a tap left at bit 31.
- A back-pressure pattern on `out_ready` exercises both the stall/hold path and back-to-back acceptance.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NFLAG = 6;

  localparam int unsigned FL_CARRY  = 0;
  localparam int unsigned FL_PARITY = 1;
  localparam int unsigned FL_AUX    = 2;
  localparam int unsigned FL_ZERO   = 3;
  localparam int unsigned FL_SIGN   = 4;
  localparam int unsigned FL_OVF    = 5;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_INC = 3'd2,
    OP_DEC = 3'd3,
    OP_NEG = 3'd4
  } op_e;

  function automatic int unsigned top_bit(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 7;
      2'd1:    return 15;
      default: return XLEN - 1;
    endcase
  endfunction
endpackage

// File: rtl/addsub_opsel.sv
module addsub_opsel
  import addsub_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] x,
  output logic [XLEN-1:0] y,
  output logic            cin,
  output logic            sub_mode,
  output logic            keep_carry
);
  always_comb begin
    x = a;
    y = b;
    cin = 1'b0;
    sub_mode = 1'b0;
    keep_carry = 1'b0;
    case (op)
      OP_SUB: begin y = ~b; cin = 1'b1; sub_mode = 1'b1; end
      OP_INC: begin y = '0; cin = 1'b1; keep_carry = 1'b1; end
      OP_DEC: begin y = '1; sub_mode = 1'b1; keep_carry = 1'b1; end
      OP_NEG: begin x = '0; y = ~a; cin = 1'b1; sub_mode = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder
  import addsub_pkg::*;
(
  input  logic [XLEN-1:0] x,
  input  logic [XLEN-1:0] y,
  input  logic            cin,
  output logic [XLEN-1:0] sum,
  output logic [XLEN:0]   carry
);
  logic [XLEN:0] wide;

  assign wide = {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, cin};
  assign sum  = wide[XLEN-1:0];

  for (genvar k = 0; k < XLEN; k++) begin : g_carry
    assign carry[k] = wide[k] ^ x[k] ^ y[k];
  end
  assign carry[XLEN] = wide[XLEN];
endmodule

// File: rtl/addsub_flaggen.sv
module addsub_flaggen
  import addsub_pkg::*;
(
  input  logic [1:0]       width_sel,
  input  logic [XLEN-1:0]  sum,
  input  logic [XLEN:0]    carry,
  input  logic             sub_mode,
  input  logic             keep_carry,
  input  logic             carry_in,
  output logic [XLEN-1:0]  res,
  output logic [NFLAG-1:0] fl,
  output logic [NFLAG-1:0] we
);
  int unsigned msb;
  logic [XLEN-1:0] mask;

  always_comb begin
    msb  = top_bit(width_sel);
    mask = '0;
    for (int i = 0; i < XLEN; i++) mask[i] = (i <= int'(msb));
    res = sum & mask;
    fl[FL_CARRY]  = keep_carry ? carry_in : (carry[msb+1] ^ sub_mode);
    fl[FL_PARITY] = ~^res[7:0];
    fl[FL_AUX]    = carry[4] ^ sub_mode;
    fl[FL_ZERO]   = (res == '0);
    fl[FL_SIGN]   = res[msb];
    fl[FL_OVF]    = carry[msb+1] ^ carry[msb];
    we = '1;
    we[FL_CARRY] = ~keep_carry;
  end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       op,
  input  logic [1:0]       width_sel,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic             carry_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  result,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] flag_we
);
  logic [XLEN-1:0]  x, y, sum, res_c;
  logic [XLEN:0]    carry;
  logic             cin, sub_mode, keep_carry;
  logic [NFLAG-1:0] fl_c, we_c;

  addsub_opsel u_sel (
    .op(op), .a(opa), .b(opb), .x(x), .y(y),
    .cin(cin), .sub_mode(sub_mode), .keep_carry(keep_carry)
  );

  addsub_adder u_add (.x(x), .y(y), .cin(cin), .sum(sum), .carry(carry));

  addsub_flaggen u_flg (
    .width_sel(width_sel), .sum(sum), .carry(carry), .sub_mode(sub_mode),
    .keep_carry(keep_carry), .carry_in(carry_in),
    .res(res_c), .fl(fl_c), .we(we_c)
  );

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      flag_we   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_c;
        flags   <= fl_c;
        flag_we <= we_c;
      end
    end
  end
endmodule

// File: rtl/addsub_flag_unit_chk.sv
module addsub_flag_unit_chk
  import addsub_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       op,
  input logic             carry_in,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  result,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] flag_we
);
  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(flags) && $stable(flag_we));

  a_r1_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r8_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (op == OP_INC || op == OP_DEC)
    |=> out_valid && !flag_we[FL_CARRY] && flags[FL_CARRY] == $past(carry_in));

  a_r10_all_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (op == OP_ADD || op == OP_SUB || op == OP_NEG)
    |=> flag_we == '1);

  a_r7_low_byte_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> flags[FL_PARITY] == ~^result[7:0]);

  a_r6_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> flags[FL_ZERO] == (result == '0));

  a_r11_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind addsub_flag_unit addsub_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op(op), .carry_in(carry_in), .out_valid(out_valid), .out_ready(out_ready),
  .result(result), .flags(flags), .flag_we(flag_we)
);

// File: tb/sim_addsub_flag_unit.sv
module sim_addsub_flag_unit;
  localparam int PERIOD = 10;
  localparam int HALF = PERIOD / 2;

  typedef struct {
    logic [31:0] res;
    logic [5:0]  fl;
    logic [5:0]  we;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, carry_in = 0, out_valid, out_ready = 0;
  logic [2:0] op = 0;
  logic [1:0] width_sel = 0;
  logic [31:0] opa = 0, opb = 0, result;
  logic [5:0] flags, flag_we;

  int n_chk = 0, n_bad = 0;
  int n_sent = 0, n_seen = 0;
  bit drv_done = 0;
  exp_t q[$];

  always #HALF clk = ~clk;

  addsub_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .width_sel(width_sel), .opa(opa), .opb(opb), .carry_in(carry_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .flags(flags), .flag_we(flag_we)
  );

  function automatic exp_t model(input logic [2:0] o, input logic [1:0] w,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic ci, input string tag);
    exp_t e;
    longint unsigned m, ua, ub, r;
    int bits;
    bit sub, sa, sb, sr;
    bits = (w == 0) ? 8 : (w == 1) ? 16 : 32;
    m = (64'd1 << bits) - 1;
    ua = a & m;
    ub = b & m;
    sub = 0;
    case (o)
      3'd1: sub = 1;
      3'd2: ub = 1;
      3'd3: begin ub = 1; sub = 1; end
      3'd4: begin ub = ua; ua = 0; sub = 1; end
      default: ;
    endcase
    r = sub ? ((ua - ub) & m) : ((ua + ub) & m);
    sa = ua[bits-1];
    sb = ub[bits-1];
    sr = r[bits-1];
    e.res = r[31:0];
    e.fl[0] = sub ? (ua < ub) : ((ua + ub) > m);
    e.fl[1] = ($countones(r[7:0]) % 2) == 0;
    e.fl[2] = sub ? ((ua & 15) < (ub & 15)) : (((ua & 15) + (ub & 15)) > 15);
    e.fl[3] = (r == 0);
    e.fl[4] = sr;
    e.fl[5] = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
    e.we = 6'b111111;
    if (o == 3'd2 || o == 3'd3) begin
      e.fl[0] = ci;
      e.we[0] = 0;
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [2:0] o, input logic [1:0] w, input logic [31:0] a,
                      input logic [31:0] b, input logic ci, input string tag);
    @(negedge clk);
    in_valid = 1; op = o; width_sel = w; opa = a; opb = b; carry_in = ci;
    forever begin
      #(HALF - 1);
      if (in_ready) begin
        q.push_back(model(o, w, a, b, ci, tag));
        n_sent++;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  string flag_req[6] = '{"R3 carry", "R7 parity", "R5 aux", "R6 zero", "R6 sign", "R4 overflow"};

  // monitor / scoreboard
  initial begin
    logic [31:0] h_res;
    logic [5:0] h_fl;
    logic [5:0] h_we;
    bit held = 0;
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 5) != 2 && (cyc % 7) != 3;
      #(HALF - 1);
      if (!rst_n) continue;
      check(in_ready == (!out_valid || out_ready), "R1 in_ready", {31'd0, in_ready}, {31'd0, !out_valid || out_ready});
      if (held && out_valid)
        check(result == h_res && flags == h_fl && flag_we == h_we, "R1 hold", result, h_res);
      held = 0;
      if (out_valid && !out_ready) begin
        held = 1; h_res = result; h_fl = flags; h_we = flag_we;
      end
      if (out_valid && out_ready) begin
        exp_t e;
        if (q.size() == 0) begin
          check(0, "R1 spurious output", result, 0);
        end else begin
          e = q.pop_front();
          n_seen++;
          check(result == e.res, {"R2 result ", e.tag}, result, e.res);
          for (int i = 0; i < 6; i++)
            check(flags[i] == e.fl[i], {flag_req[i], " ", e.tag}, {31'd0, flags[i]}, {31'd0, e.fl[i]});
          check(flag_we == e.we, {"R8/R10 flag_we ", e.tag}, {26'd0, flag_we}, {26'd0, e.we});
        end
      end
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    #(HALF - 1);
    check(out_valid == 0, "R11 out_valid in reset", {31'd0, out_valid}, 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(in_ready == 1, "R11 in_ready after reset", {31'd0, in_ready}, 1);
    send(3'd0, 2'd0, 32'h80, 32'h80, 0, "R3 R4 80h+80h");
    send(3'd0, 2'd1, 32'h7FFF, 32'h1, 0, "R4 R6 7FFFh+1");
    send(3'd1, 2'd2, 32'h1234_5678, 32'h1234_5678, 0, "R6 sub equal");
    send(3'd1, 2'd0, 32'h10, 32'h01, 0, "R5 nibble borrow");
    send(3'd1, 2'd1, 32'h0001, 32'h0002, 0, "R3 borrow");
    send(3'd4, 2'd0, 32'h0, 32'h0, 0, "R9 neg zero");
    send(3'd4, 2'd0, 32'h80, 32'h0, 0, "R9 neg min byte");
    send(3'd4, 2'd2, 32'h8000_0000, 32'h0, 0, "R9 neg min dword");
    send(3'd4, 2'd1, 32'h0010, 32'h0, 0, "R9 neg clear nibble");
    send(3'd2, 2'd0, 32'hFF, 32'h0, 1, "R8 inc wrap carry_in 1");
    send(3'd2, 2'd1, 32'h7FFF, 32'h0, 0, "R8 inc carry_in 0");
    send(3'd3, 2'd2, 32'h0, 32'h0, 1, "R8 dec zero");
    send(3'd0, 2'd0, 32'hABCD_EF0F, 32'h1234_5601, 0, "R2 upper ignored");
    send(3'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 0, "R2 width 3");
    send(3'd0, 2'd2, 32'h00FF_0001, 32'h2, 0, "R7 low byte parity");
    send(3'd6, 2'd0, 32'h11, 32'h22, 0, "R2 spare code");
    for (int i = 0; i < 400; i++)
      send(3'($urandom_range(0, 5)), 2'($urandom_range(0, 3)), $urandom, $urandom,
           1'($urandom_range(0, 1)), "random");
    while (n_seen < n_sent) @(negedge clk);
    repeat (3) @(negedge clk);
    drv_done = 1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule